// File: doc/BRIEF.md
# Core Low-Power State Controller

This block sequences the power state of a single processor core. Pipeline logic reports three kinds of entry request: a halt, an mwait (with a hint that picks the light or the deep state), and a read of the deep-sleep port in the power-control I/O block. The controller moves the core into a light sleep, a deep sleep, a stop-grant hold or a short snoop-service excursion. It returns the core to the running state when a wake event arrives. A clock-gate enable tells the clock tree when the core may stop. Two one-cycle pulses report a stop-grant acknowledge and the end of each snoop service.

There are two light-sleep flavours. One is entered by halt and the other by mwait. They differ only in that the mwait flavour also wakes on a write to the monitored address. Stop-clock and snoop excursions remember the sleep state they interrupted and go back to it. After a system-management interrupt handler finishes, a select input chooses whether the core resumes running or drops back into halt sleep.

Top module: `core_pstate_ctrl`

## Requirements
- R1: `state_code` encodes the states as 0 running, 1 halt-sleep, 2 mwait-sleep, 3 deep-sleep, 4 stop-grant and 5 snoop-service. While running, a `halt_exec` pulse shows code 1 on the next cycle. An `mwait_exec` pulse with `mwait_hint_c2`=0 shows code 2. Among same-cycle entry requests, `lvl2_io_read` wins over `mwait_exec`, which wins over `halt_exec`.
- R2: In codes 1, 2 or 3, a pulse on any of `wake_smi`, `wake_init`, `wake_lint0`, `wake_lint1` or `wake_bus_msg` shows code 0 on the next cycle.
- R3: A cycle with `rst` high gives code 0 on the next cycle from any state, and all pulse outputs low, whatever else is asserted.
- R4: In code 1 or 2 with `stopclk_req` high and no wake, the next state is 4. State 4 holds while the request stays high. It ignores wakes and snoops. After release it returns to the same light state it left.
- R5: `monitor_hit` wakes the core to code 0 from code 2 only. In codes 1 and 3 it has no effect.
- R6: While running, `lvl2_io_read`, or `mwait_exec` with `mwait_hint_c2`=1, shows code 3 on the next cycle. Stop-clock does not move the core out of code 3.
- R7: `stop_grant_ack` is high for exactly one cycle, the first cycle that shows code 3. It pulses only if `stopclk_req` was high in the cycle the deep-sleep entry was requested. Otherwise the entry raises no pulse.
- R8: In codes 1, 2 or 3 with no wake and no stop-clock, a snoop moves the core to code 5. Code 5 is shown for exactly `SNOOP_CYCLES` cycles. The next cycle shows the state the core left, and `snoop_done` is high in that same cycle.
- R9: With `DUAL_CORE`=1, both `snoop_bus` and `snoop_peer` start a snoop service. With `DUAL_CORE`=0, `snoop_peer` is ignored and only `snoop_bus` starts one.
- R10: A system-management wake taken to code 0 marks a handler as active. While running, a `smi_done` pulse with the mark set returns the core to code 1 if `smi_resume_halt`=1, or keeps it at code 0 if it is 0, and clears the mark. Without the mark, `smi_done` is ignored.
- R11: When events coincide in a light state, the order of priority is reset, then wake, then stop-clock, then snoop.
- R12: A wake that arrives during snoop service is held. When the service ends, `snoop_done` pulses and the core shows code 0 instead of returning to sleep.
- R13: `clk_en` is high in codes 0 and 5 and low in codes 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_exec | input | 1 | Halt executed (pulse) |
| mwait_exec | input | 1 | Mwait executed (pulse) |
| mwait_hint_c2 | input | 1 | Mwait hint: 1 selects deep sleep |
| lvl2_io_read | input | 1 | Deep-sleep port read decoded (pulse) |
| wake_smi | input | 1 | System-management interrupt |
| wake_init | input | 1 | Init request |
| wake_lint0 | input | 1 | Local interrupt line 0 |
| wake_lint1 | input | 1 | Local interrupt line 1 |
| wake_bus_msg | input | 1 | Interrupt message from the bus |
| monitor_hit | input | 1 | Monitored address was written |
| smi_done | input | 1 | Management handler finished (pulse) |
| smi_resume_halt | input | 1 | Resume target after handler: 1 halt-sleep, 0 running |
| stopclk_req | input | 1 | Stop-clock request level |
| snoop_bus | input | 1 | Snoop from the system bus |
| snoop_peer | input | 1 | Snoop from the sibling core |
| state_code | output | 3 | Current state code |
| clk_en | output | 1 | Core clock enable |
| stop_grant_ack | output | 1 | Stop-grant acknowledge pulse |
| snoop_done | output | 1 | Snoop service finished pulse |

## Verification
The hardest situations to reach are the nested ones. Examples are a wake that lands inside a snoop service entered from mwait sleep, a stop-clock release that must return to the correct light flavour, and a handler-return select that is only valid after a management wake. Long directed sequences build each nesting on purpose. Seeded random stimulus with low per-cycle event rates then keeps the core asleep long enough for snoops, stop-clock and wakes to overlap. Every cycle is compared with a bench model of both a dual-core and a single-core instance.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

    typedef enum logic [2:0] {
        PS_ACTIVE = 3'd0,
        PS_HALT   = 3'd1,
        PS_MWAIT  = 3'd2,
        PS_DEEP   = 3'd3,
        PS_STOPG  = 3'd4,
        PS_SNOOP  = 3'd5
    } pstate_e;

    typedef struct packed {
        logic smi;
        logic init;
        logic lint0;
        logic lint1;
        logic bus_msg;
        logic monitor;
    } wake_evt_t;

    typedef struct packed {
        logic halt;
        logic mwait;
        logic mwait_c2;
        logic lvl2_rd;
    } entry_req_t;

    typedef struct packed {
        logic done;
        logic resume_halt;
    } smi_ret_t;

    function automatic logic is_light(pstate_e s);
        return (s == PS_HALT) || (s == PS_MWAIT);
    endfunction

    function automatic logic clock_may_stop(pstate_e s);
        return !((s == PS_ACTIVE) || (s == PS_SNOOP));
    endfunction

endpackage

// File: rtl/cpw_wake_merge.sv
module cpw_wake_merge
    import cpw_pkg::*;
#(
    parameter int DUAL_CORE = 1
) (
    input  wake_evt_t evt,
    input  logic      monitor_ok,
    input  logic      snoop_bus,
    input  logic      snoop_peer,
    output logic      wake_any,
    output logic      wake_smi,
    output logic      snoop_req
);
    localparam logic PEER_EN = (DUAL_CORE != 0);

    always_comb begin
        wake_smi  = evt.smi;
        wake_any  = evt.smi | evt.init | evt.lint0 | evt.lint1 | evt.bus_msg
                  | (evt.monitor & monitor_ok);
        snoop_req = snoop_bus | (snoop_peer & PEER_EN);
    end
endmodule

// File: rtl/cpw_snoop_timer.sv
module cpw_snoop_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expire
);
    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CW-1:0] START = CW'(CYCLES - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= START;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expire = (remain == '0);
endmodule

// File: rtl/cpw_state_next.sv
module cpw_state_next
    import cpw_pkg::*;
(
    input  pstate_e    state,
    input  pstate_e    ret_state,
    input  logic       wake_any,
    input  logic       wake_smi,
    input  logic       snoop_req,
    input  logic       stopclk,
    input  entry_req_t entry,
    input  smi_ret_t   smi_ret,
    input  logic       smi_act,
    input  logic       pend_wake,
    input  logic       pend_smi,
    input  logic       tmr_expire,
    output pstate_e    nxt_state,
    output pstate_e    nxt_ret,
    output logic       nxt_smi_act,
    output logic       nxt_pend_wake,
    output logic       nxt_pend_smi,
    output logic       load_tmr,
    output logic       ack_set,
    output logic       done_set
);
    always_comb begin
        nxt_state     = state;
        nxt_ret       = ret_state;
        nxt_smi_act   = smi_act;
        nxt_pend_wake = pend_wake;
        nxt_pend_smi  = pend_smi;
        load_tmr      = 1'b0;
        ack_set       = 1'b0;
        done_set      = 1'b0;
        unique case (state)
            PS_ACTIVE: begin
                nxt_smi_act = wake_smi | (smi_act & ~smi_ret.done);
                if (smi_ret.done && smi_act) begin
                    nxt_state = smi_ret.resume_halt ? PS_HALT : PS_ACTIVE;
                end else if (entry.lvl2_rd) begin
                    nxt_state = PS_DEEP;
                    ack_set   = stopclk;
                end else if (entry.mwait) begin
                    if (entry.mwait_c2) begin
                        nxt_state = PS_DEEP;
                        ack_set   = stopclk;
                    end else begin
                        nxt_state = PS_MWAIT;
                    end
                end else if (entry.halt) begin
                    nxt_state = PS_HALT;
                end
            end
            PS_HALT, PS_MWAIT, PS_DEEP: begin
                if (wake_any) begin
                    nxt_state   = PS_ACTIVE;
                    nxt_smi_act = smi_act | wake_smi;
                end else if (stopclk && is_light(state)) begin
                    nxt_state = PS_STOPG;
                    nxt_ret   = state;
                end else if (snoop_req) begin
                    nxt_state     = PS_SNOOP;
                    nxt_ret       = state;
                    load_tmr      = 1'b1;
                    nxt_pend_wake = 1'b0;
                    nxt_pend_smi  = 1'b0;
                end
            end
            PS_STOPG: begin
                if (!stopclk) begin
                    nxt_state = ret_state;
                end
            end
            PS_SNOOP: begin
                if (tmr_expire) begin
                    done_set      = 1'b1;
                    nxt_pend_wake = 1'b0;
                    nxt_pend_smi  = 1'b0;
                    if (pend_wake || wake_any) begin
                        nxt_state   = PS_ACTIVE;
                        nxt_smi_act = smi_act | pend_smi | wake_smi;
                    end else begin
                        nxt_state = ret_state;
                    end
                end else begin
                    nxt_pend_wake = pend_wake | wake_any;
                    nxt_pend_smi  = pend_smi | wake_smi;
                end
            end
            default: begin
                nxt_state = PS_ACTIVE;
            end
        endcase
    end
endmodule

// File: rtl/core_pstate_ctrl.sv
module core_pstate_ctrl
    import cpw_pkg::*;
#(
    parameter int SNOOP_CYCLES = 4,
    parameter int DUAL_CORE    = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_exec,
    input  logic       mwait_exec,
    input  logic       mwait_hint_c2,
    input  logic       lvl2_io_read,
    input  logic       wake_smi,
    input  logic       wake_init,
    input  logic       wake_lint0,
    input  logic       wake_lint1,
    input  logic       wake_bus_msg,
    input  logic       monitor_hit,
    input  logic       smi_done,
    input  logic       smi_resume_halt,
    input  logic       stopclk_req,
    input  logic       snoop_bus,
    input  logic       snoop_peer,
    output logic [2:0] state_code,
    output logic       clk_en,
    output logic       stop_grant_ack,
    output logic       snoop_done
);
    pstate_e    state_q, ret_q, nxt_state, nxt_ret;
    logic       smi_act_q, pend_q, pend_smi_q;
    logic       nxt_smi_act, nxt_pend, nxt_pend_smi;
    logic       ack_q, done_q, ack_set, done_set;
    logic       wake_any, wake_smi_q, snoop_req, load_tmr, tmr_expire, monitor_ok;
    wake_evt_t  evt;
    entry_req_t entry;
    smi_ret_t   smi_ret;

    assign evt     = '{smi: wake_smi, init: wake_init, lint0: wake_lint0,
                       lint1: wake_lint1, bus_msg: wake_bus_msg, monitor: monitor_hit};
    assign entry   = '{halt: halt_exec, mwait: mwait_exec,
                       mwait_c2: mwait_hint_c2, lvl2_rd: lvl2_io_read};
    assign smi_ret = '{done: smi_done, resume_halt: smi_resume_halt};

    assign monitor_ok = (state_q == PS_MWAIT) ||
                        ((state_q == PS_SNOOP) && (ret_q == PS_MWAIT));

    cpw_wake_merge #(.DUAL_CORE(DUAL_CORE)) u_wake (
        .evt        (evt),
        .monitor_ok (monitor_ok),
        .snoop_bus  (snoop_bus),
        .snoop_peer (snoop_peer),
        .wake_any   (wake_any),
        .wake_smi   (wake_smi_q),
        .snoop_req  (snoop_req)
    );

    cpw_snoop_timer #(.CYCLES(SNOOP_CYCLES)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (load_tmr),
        .expire (tmr_expire)
    );

    cpw_state_next u_next (
        .state         (state_q),
        .ret_state     (ret_q),
        .wake_any      (wake_any),
        .wake_smi      (wake_smi_q),
        .snoop_req     (snoop_req),
        .stopclk       (stopclk_req),
        .entry         (entry),
        .smi_ret       (smi_ret),
        .smi_act       (smi_act_q),
        .pend_wake     (pend_q),
        .pend_smi      (pend_smi_q),
        .tmr_expire    (tmr_expire),
        .nxt_state     (nxt_state),
        .nxt_ret       (nxt_ret),
        .nxt_smi_act   (nxt_smi_act),
        .nxt_pend_wake (nxt_pend),
        .nxt_pend_smi  (nxt_pend_smi),
        .load_tmr      (load_tmr),
        .ack_set       (ack_set),
        .done_set      (done_set)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PS_ACTIVE;
            ret_q      <= PS_ACTIVE;
            smi_act_q  <= 1'b0;
            pend_q     <= 1'b0;
            pend_smi_q <= 1'b0;
            ack_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            state_q    <= nxt_state;
            ret_q      <= nxt_ret;
            smi_act_q  <= nxt_smi_act;
            pend_q     <= nxt_pend;
            pend_smi_q <= nxt_pend_smi;
            ack_q      <= ack_set;
            done_q     <= done_set;
        end
    end

    assign state_code     = state_q;
    assign clk_en         = ~clock_may_stop(state_q);
    assign stop_grant_ack = ack_q;
    assign snoop_done     = done_q;
endmodule

// File: rtl/cpw_checker.sv
module cpw_checker (
    input logic       clk,
    input logic       rst,
    input logic [2:0] state_code,
    input logic       stop_grant_ack,
    input logic       snoop_done,
    input logic       stopclk_req,
    input logic       wake_smi,
    input logic       wake_init,
    input logic       wake_lint0,
    input logic       wake_lint1,
    input logic       wake_bus_msg,
    input logic       monitor_hit
);
    logic any_wake;
    assign any_wake = wake_smi | wake_init | wake_lint0 | wake_lint1 | wake_bus_msg;

    a_r3_reset_active: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> state_code == 3'd0);

    a_r2_wake_runs: assert property (@(posedge clk) disable iff (rst)
        ((state_code == 3'd1 || state_code == 3'd2 || state_code == 3'd3) && any_wake)
        |=> state_code == 3'd0);

    a_r4_stopg_return: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd4 && !stopclk_req) |=> (state_code == 3'd1 || state_code == 3'd2));

    a_r5_monitor_wakes: assert property (@(posedge clk) disable iff (rst)
        (state_code == 3'd2 && monitor_hit) |=> state_code == 3'd0);

    a_r7_ack_on_entry: assert property (@(posedge clk) disable iff (rst)
        stop_grant_ack |-> (state_code == 3'd3 && $past(state_code) == 3'd0 && $past(stopclk_req)));

    a_r8_done_on_exit: assert property (@(posedge clk) disable iff (rst)
        snoop_done |-> ($past(state_code) == 3'd5 && state_code != 3'd5));

    a_r8_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stop_grant_ack, snoop_done}));
endmodule

bind core_pstate_ctrl cpw_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .state_code     (state_code),
    .stop_grant_ack (stop_grant_ack),
    .snoop_done     (snoop_done),
    .stopclk_req    (stopclk_req),
    .wake_smi       (wake_smi),
    .wake_init      (wake_init),
    .wake_lint0     (wake_lint0),
    .wake_lint1     (wake_lint1),
    .wake_bus_msg   (wake_bus_msg),
    .monitor_hit    (monitor_hit)
);

// File: tb/core_pstate_ctrl_bench.sv
`timescale 1ns/1ps
module core_pstate_ctrl_bench;
    localparam int NSNP = 4;
    localparam int S_RUN = 0, S_HLT = 1, S_MWT = 2, S_DP = 3, S_SG = 4, S_SN = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt_exec = 0, mwait_exec = 0, mwait_hint_c2 = 0, lvl2_io_read = 0;
    logic wake_smi = 0, wake_init = 0, wake_lint0 = 0, wake_lint1 = 0, wake_bus_msg = 0;
    logic monitor_hit = 0, smi_done = 0, smi_resume_halt = 0, stopclk_req = 0;
    logic snoop_bus = 0, snoop_peer = 0;
    logic [2:0] st_d, st_s;
    logic ce_d, ce_s, ack_d, ack_s, dn_d, dn_s;

    int checks = 0;
    int errors = 0;
    string cur_req = "R3";

    typedef struct {
        int st; int ret; int cnt;
        bit pend; bit psmi; bit sact; bit ack; bit done;
    } mdl_t;
    mdl_t md, ms;

    always #2 clk = ~clk;

    core_pstate_ctrl #(.SNOOP_CYCLES(NSNP), .DUAL_CORE(1)) u_core_pstate_ctrl (
        .clk(clk), .rst(rst), .halt_exec(halt_exec), .mwait_exec(mwait_exec),
        .mwait_hint_c2(mwait_hint_c2), .lvl2_io_read(lvl2_io_read), .wake_smi(wake_smi),
        .wake_init(wake_init), .wake_lint0(wake_lint0), .wake_lint1(wake_lint1),
        .wake_bus_msg(wake_bus_msg), .monitor_hit(monitor_hit), .smi_done(smi_done),
        .smi_resume_halt(smi_resume_halt), .stopclk_req(stopclk_req), .snoop_bus(snoop_bus),
        .snoop_peer(snoop_peer), .state_code(st_d), .clk_en(ce_d),
        .stop_grant_ack(ack_d), .snoop_done(dn_d));

    core_pstate_ctrl #(.SNOOP_CYCLES(NSNP), .DUAL_CORE(0)) u_core_pstate_ctrl_single (
        .clk(clk), .rst(rst), .halt_exec(halt_exec), .mwait_exec(mwait_exec),
        .mwait_hint_c2(mwait_hint_c2), .lvl2_io_read(lvl2_io_read), .wake_smi(wake_smi),
        .wake_init(wake_init), .wake_lint0(wake_lint0), .wake_lint1(wake_lint1),
        .wake_bus_msg(wake_bus_msg), .monitor_hit(monitor_hit), .smi_done(smi_done),
        .smi_resume_halt(smi_resume_halt), .stopclk_req(stopclk_req), .snoop_bus(snoop_bus),
        .snoop_peer(snoop_peer), .state_code(st_s), .clk_en(ce_s),
        .stop_grant_ack(ack_s), .snoop_done(dn_s));

    // Reference model built from the requirements.
    function automatic mdl_t mstep(mdl_t m, bit dual);
        mdl_t n = m;
        bit w, sn, wsmi;
        n.ack = 0; n.done = 0;
        if (rst) begin
            n.st = S_RUN; n.ret = S_RUN; n.cnt = 0;
            n.pend = 0; n.psmi = 0; n.sact = 0;
            return n;
        end
        wsmi = wake_smi;
        w = wake_smi | wake_init | wake_lint0 | wake_lint1 | wake_bus_msg |
            (monitor_hit && (m.st == S_MWT || (m.st == S_SN && m.ret == S_MWT)));
        sn = snoop_bus | (dual & snoop_peer);
        case (m.st)
            S_RUN: begin
                n.sact = wsmi | (m.sact & ~smi_done);
                if (smi_done && m.sact) n.st = smi_resume_halt ? S_HLT : S_RUN;
                else if (lvl2_io_read || (mwait_exec && mwait_hint_c2)) begin
                    n.st = S_DP; n.ack = stopclk_req;
                end
                else if (mwait_exec) n.st = S_MWT;
                else if (halt_exec) n.st = S_HLT;
            end
            S_HLT, S_MWT, S_DP: begin
                if (w) begin n.st = S_RUN; n.sact = m.sact | wsmi; end
                else if (stopclk_req && m.st != S_DP) begin n.st = S_SG; n.ret = m.st; end
                else if (sn) begin
                    n.st = S_SN; n.ret = m.st; n.cnt = NSNP - 1; n.pend = 0; n.psmi = 0;
                end
            end
            S_SG: if (!stopclk_req) n.st = m.ret;
            S_SN: begin
                if (m.cnt == 0) begin
                    n.done = 1; n.pend = 0; n.psmi = 0;
                    if (m.pend || w) begin n.st = S_RUN; n.sact = m.sact | m.psmi | wsmi; end
                    else n.st = m.ret;
                end else begin
                    n.cnt = m.cnt - 1; n.pend = m.pend | w; n.psmi = m.psmi | wsmi;
                end
            end
            default: n.st = S_RUN;
        endcase
        return n;
    endfunction

    function automatic bit exp_ce(int s);
        return (s == S_RUN) || (s == S_SN);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        md = mstep(md, 1'b1);
        ms = mstep(ms, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk(cur_req, "state", int'(st_d), md.st);
        chk("R13", "clk_en", int'(ce_d), int'(exp_ce(md.st)));
        chk("R7", "stop_grant_ack", int'(ack_d), int'(md.ack));
        chk("R8", "snoop_done", int'(dn_d), int'(md.done));
        chk("R9", "single state", int'(st_s), ms.st);
        chk("R9", "single snoop_done", int'(dn_s), int'(ms.done));
    endtask

    task automatic clr();
        halt_exec = 0; mwait_exec = 0; mwait_hint_c2 = 0; lvl2_io_read = 0;
        wake_smi = 0; wake_init = 0; wake_lint0 = 0; wake_lint1 = 0; wake_bus_msg = 0;
        monitor_hit = 0; smi_done = 0; snoop_bus = 0; snoop_peer = 0; rst = 0;
    endtask

    task automatic go_reset();
        clr(); stopclk_req = 0; rst = 1; tick(); rst = 0;
    endtask

    task automatic pulse_tick();
        tick(); clr();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C1A_57A7));
        @(negedge clk);
        cur_req = "R3"; go_reset(); tick();
        // R1 halt and mwait entries, priority between them
        cur_req = "R1"; halt_exec = 1; pulse_tick(); tick();
        go_reset(); mwait_exec = 1; halt_exec = 1; pulse_tick();
        go_reset(); lvl2_io_read = 1; mwait_exec = 1; pulse_tick();
        // R2 wake from each sleep
        cur_req = "R2"; wake_lint1 = 1; pulse_tick();
        halt_exec = 1; pulse_tick(); wake_bus_msg = 1; pulse_tick();
        // R4 stop-clock round trip from both light states
        cur_req = "R4"; mwait_exec = 1; pulse_tick();
        stopclk_req = 1; tick(); wake_init = 1; snoop_bus = 1; pulse_tick(); tick();
        stopclk_req = 0; tick(); tick();
        halt_exec = 0; wake_lint0 = 1; pulse_tick();
        halt_exec = 1; pulse_tick(); stopclk_req = 1; tick(); stopclk_req = 0; tick();
        // R5 monitor only wakes mwait sleep
        cur_req = "R5"; monitor_hit = 1; pulse_tick(); tick();
        wake_init = 1; pulse_tick(); lvl2_io_read = 1; pulse_tick();
        monitor_hit = 1; pulse_tick(); wake_smi = 0; wake_init = 1; pulse_tick();
        mwait_exec = 1; pulse_tick(); monitor_hit = 1; pulse_tick();
        // R6 / R7 deep entry with and without stop-clock
        cur_req = "R6"; mwait_exec = 1; mwait_hint_c2 = 1; pulse_tick();
        stopclk_req = 1; tick(); tick(); stopclk_req = 0; wake_lint0 = 1; pulse_tick();
        cur_req = "R7"; stopclk_req = 1; lvl2_io_read = 1; pulse_tick(); tick();
        stopclk_req = 0; wake_init = 1; pulse_tick();
        // R8 / R9 snoop service from halt and deep sleep, bus and peer
        cur_req = "R8"; halt_exec = 1; pulse_tick();
        snoop_bus = 1; pulse_tick(); for (int i = 0; i < NSNP + 2; i++) tick();
        cur_req = "R9"; snoop_peer = 1; pulse_tick(); for (int i = 0; i < NSNP + 2; i++) tick();
        wake_init = 1; pulse_tick(); lvl2_io_read = 1; pulse_tick();
        cur_req = "R8"; snoop_bus = 1; pulse_tick(); for (int i = 0; i < NSNP + 1; i++) tick();
        wake_init = 1; pulse_tick();
        // R10 handler return target
        cur_req = "R10"; smi_done = 1; smi_resume_halt = 1; pulse_tick();
        halt_exec = 1; pulse_tick(); wake_smi = 1; pulse_tick(); tick();
        smi_done = 1; smi_resume_halt = 1; pulse_tick(); tick();
        wake_smi = 1; pulse_tick(); smi_done = 1; smi_resume_halt = 0; pulse_tick();
        smi_done = 1; smi_resume_halt = 1; pulse_tick();
        // R11 coincident events in light sleep
        cur_req = "R11"; halt_exec = 1; pulse_tick();
        wake_lint0 = 1; stopclk_req = 1; snoop_bus = 1; pulse_tick();
        stopclk_req = 0; halt_exec = 1; pulse_tick();
        stopclk_req = 1; snoop_bus = 1; pulse_tick(); stopclk_req = 0; tick();
        // R12 wake held across snoop service from mwait sleep
        cur_req = "R12"; wake_init = 1; pulse_tick(); mwait_exec = 1; pulse_tick();
        snoop_bus = 1; pulse_tick(); monitor_hit = 1; pulse_tick();
        for (int i = 0; i < NSNP + 1; i++) tick();
        halt_exec = 1; pulse_tick(); snoop_bus = 1; pulse_tick(); tick(); wake_smi = 1; pulse_tick();
        for (int i = 0; i < NSNP; i++) tick();
        smi_done = 1; smi_resume_halt = 1; pulse_tick();
        // R3 reset from a sleep state with events pending
        cur_req = "R3"; stopclk_req = 1; tick(); rst = 1; wake_init = 1; halt_exec = 1; pulse_tick();
        stopclk_req = 0; tick();
        // Random mix; every check compares with the model (R1..R13)
        cur_req = "R2";
        for (int c = 0; c < 5000; c++) begin
            halt_exec       = ($urandom_range(99) < 10);
            mwait_exec      = ($urandom_range(99) < 8);
            mwait_hint_c2   = ($urandom_range(1) == 1);
            lvl2_io_read    = ($urandom_range(99) < 4);
            wake_smi        = ($urandom_range(99) < 2);
            wake_init       = ($urandom_range(99) < 2);
            wake_lint0      = ($urandom_range(99) < 2);
            wake_lint1      = ($urandom_range(99) < 2);
            wake_bus_msg    = ($urandom_range(99) < 2);
            monitor_hit     = ($urandom_range(99) < 4);
            smi_done        = ($urandom_range(99) < 10);
            smi_resume_halt = ($urandom_range(1) == 1);
            snoop_bus       = ($urandom_range(99) < 7);
            snoop_peer      = ($urandom_range(99) < 7);
            if ($urandom_range(99) < 6) stopclk_req = ~stopclk_req;
            rst             = ($urandom_range(999) < 4);
            tick();
        end
        clr(); tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule